// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block merges the four interrupt conditions of a UART into one interrupt request line for the CPU. It also produces an identification code that names the most urgent pending source. The four conditions are receiver line status, receive data available, receiver time-out and transmit holding empty. Each condition passes through its own enable before it can compete for the line. The receive-data enable is shared: it gates both the data-available source and the time-out source. The transmitter's empty flag is converted into a one-shot pending event. That event is raised when the transmitter becomes empty and is withdrawn when the CPU reads the identification while the transmit source is the one shown.

The surrounding UART supplies the raw condition flags: character present, FIFO trigger level reached, time-out, the four error flags and transmitter empty. It also supplies the mode flag and the identification-read strobe. The block returns the interrupt line, the 4-bit identification value and a data-ready status bit. In FIFO mode the data-available source follows the trigger level. In non-FIFO mode it follows the presence of a single character. The data-ready status bit always follows character presence only.

Top module: `uart_irq_arbiter`

## Requirements
- R1: While reset is asserted and until the first input is sampled after release, `irq` is 0, `irq_id` is 4'b0001 and `rx_ready` is 0.
- R2: The line-status source is active when any bit of `err_flags` is 1 and `en_line_stat` is 1. It has the highest priority and is reported as `irq_id` = 4'b0110 (source code 3'b011, bit 0 = 0).
- R3: The data-available source is gated by `en_rx_data`. It follows `rx_char_present` when `fifo_mode` is 0 and follows `rx_at_trigger` when `fifo_mode` is 1. It ranks below line status and is reported as 4'b0100 (code 3'b010).
- R4: The time-out source is active only when `fifo_mode`, `en_rx_data` and `rx_timeout` are all 1. It ranks below data available and above transmit empty, and is reported as 4'b1100 (code 3'b110).
- R5: The transmit-empty source becomes pending when `thr_empty` goes from 0 to 1. It stays pending while `thr_empty` remains 1, even if `en_thr_empty` is 0 at that time. It is reported, at the lowest priority, as 4'b0010 (code 3'b001) only while `en_thr_empty` is 1. It is withdrawn when `thr_empty` returns to 0.
- R6: If `id_rd` is 1 in a cycle where `irq_id` reads 4'b0010, the transmit-empty source is cleared. It stays cleared while `thr_empty` stays 1 and is raised again only on the next 0-to-1 transition. An `id_rd` while another code is shown leaves the transmit-empty source pending.
- R7: With no enabled source pending, `irq_id` is 4'b0001 (bit 0 = 1 means nothing pending) and `irq` is 0.
- R8: `irq` and `irq_id` are registered. They reflect the inputs sampled at the previous rising clock edge, and `irq` is 1 exactly when `irq_id` bit 0 is 0.
- R9: `rx_ready` equals `rx_char_present` as sampled at the previous clock edge, in both modes and regardless of `rx_at_trigger`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_mode | input | 1 | 1 selects FIFO mode |
| en_thr_empty | input | 1 | Enable for the transmit-empty source |
| en_rx_data | input | 1 | Enable shared by data-available and time-out sources |
| en_line_stat | input | 1 | Enable for the line-status source |
| thr_empty | input | 1 | Transmit holding register (or FIFO) is empty |
| rx_char_present | input | 1 | At least one unread received character exists |
| rx_at_trigger | input | 1 | Receive FIFO level has reached the trigger level |
| rx_timeout | input | 1 | Raw receiver time-out condition |
| err_flags | input | ERR_W | Overrun, parity, framing and break error flags |
| id_rd | input | 1 | Strobe: the identification value is being read |
| irq | output | 1 | Interrupt request to the CPU |
| irq_id | output | 4 | Identification: {source code, no-pending bit} |
| rx_ready | output | 1 | Data-ready status, character presence only |

## Verification
On every cycle the assertions check four things. Line status wins whenever an enabled error was sampled. A disabled set of enables yields no request. The time-out code never appears without FIFO mode. A read of a shown transmit-empty code removes that code at the next update. They also tie `irq` to the pending bit of `irq_id` and check the one-cycle following of `rx_ready`. Other behaviour depends on history and can only be shown by the bench scenarios. These are the arming of the transmit-empty event on a 0-to-1 transition, its survival across a read that showed another source, its silence while the empty flag stays high after a clear, and its retention while disabled. The bench also sweeps every combination of mode, enables, receive flags and error bits against an arithmetic priority model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int ID_W   = 4;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    SRC_NONE = 3'b000,
    SRC_TE   = 3'b001,
    SRC_DA   = 3'b010,
    SRC_LS   = 3'b011,
    SRC_TO   = 3'b110
  } src_code_e;

  typedef struct packed {
    logic ls;
    logic da;
    logic to;
    logic te;
  } src_vec_t;

  function automatic logic [ID_W-1:0] make_id(src_code_e code, logic none_pend);
    return {code, none_pend};
  endfunction

  localparam logic [ID_W-1:0] ID_IDLE = {SRC_NONE, 1'b1};
  localparam logic [ID_W-1:0] ID_TE   = {SRC_TE, 1'b0};

endpackage

// File: rtl/uart_irq_te_track.sv
module uart_irq_te_track (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic clr,
  output logic te_live
);

  logic thr_q, thr_d;
  logic armed_q, armed_d;
  logic rise;

  always_comb begin
    rise    = thr_empty & ~thr_q;
    te_live = (armed_q | rise) & thr_empty & ~clr;
    armed_d = te_live;
    thr_d   = thr_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      thr_q   <= thr_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/uart_irq_src_gate.sv
module uart_irq_src_gate
  import uart_irq_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic             fifo_mode,
  input  logic             en_thr_empty,
  input  logic             en_rx_data,
  input  logic             en_line_stat,
  input  logic             te_live,
  input  logic             rx_char_present,
  input  logic             rx_at_trigger,
  input  logic             rx_timeout,
  input  logic [ERR_W-1:0] err_flags,
  output src_vec_t         src
);

  logic any_err;
  logic da_cond;

  always_comb begin
    any_err = |err_flags;
    da_cond = fifo_mode ? rx_at_trigger : rx_char_present;
    src.ls  = en_line_stat & any_err;
    src.da  = en_rx_data & da_cond;
    src.to  = en_rx_data & fifo_mode & rx_timeout;
    src.te  = en_thr_empty & te_live;
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  src_vec_t        src,
  output logic [ID_W-1:0] id_next,
  output logic            any_pend
);

  src_code_e code;

  always_comb begin
    any_pend = |src;
    if (src.ls)      code = SRC_LS;
    else if (src.da) code = SRC_DA;
    else if (src.to) code = SRC_TO;
    else if (src.te) code = SRC_TE;
    else             code = SRC_NONE;
    id_next = make_id(code, ~any_pend);
  end

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int ERR_W      = 4,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             en_thr_empty,
  input  logic             en_rx_data,
  input  logic             en_line_stat,
  input  logic             thr_empty,
  input  logic             rx_char_present,
  input  logic             rx_at_trigger,
  input  logic             rx_timeout,
  input  logic [ERR_W-1:0] err_flags,
  input  logic             id_rd,
  output logic             irq,
  output logic [ID_W-1:0]  irq_id,
  output logic             rx_ready
);

  localparam int SYNC_LAST = RST_STAGES - 1;

  logic [SYNC_LAST:0] rst_pipe;
  logic               rst_s;

  generate
    if (RST_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_s = rst_pipe[SYNC_LAST];

  logic            te_clr;
  logic            te_live;
  src_vec_t        src;
  logic [ID_W-1:0] id_d;
  logic            pend_d;
  logic            irq_d;
  logic            rdy_d;

  always_comb begin
    te_clr = id_rd & (irq_id == ID_TE);
  end

  uart_irq_te_track u_te (
    .clk       (clk),
    .rst_n     (rst_s),
    .thr_empty (thr_empty),
    .clr       (te_clr),
    .te_live   (te_live)
  );

  uart_irq_src_gate #(.ERR_W(ERR_W)) u_gate (
    .fifo_mode       (fifo_mode),
    .en_thr_empty    (en_thr_empty),
    .en_rx_data      (en_rx_data),
    .en_line_stat    (en_line_stat),
    .te_live         (te_live),
    .rx_char_present (rx_char_present),
    .rx_at_trigger   (rx_at_trigger),
    .rx_timeout      (rx_timeout),
    .err_flags       (err_flags),
    .src             (src)
  );

  uart_irq_prio u_prio (
    .src      (src),
    .id_next  (id_d),
    .any_pend (pend_d)
  );

  always_comb begin
    irq_d = pend_d;
    rdy_d = rx_char_present;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      irq      <= 1'b0;
      irq_id   <= ID_IDLE;
      rx_ready <= 1'b0;
    end else begin
      irq      <= irq_d;
      irq_id   <= id_d;
      rx_ready <= rdy_d;
    end
  end

endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk #(
  parameter int ERR_W = 4
) (
  input logic             clk,
  input logic             rst_s,
  input logic             fifo_mode,
  input logic             en_thr_empty,
  input logic             en_rx_data,
  input logic             en_line_stat,
  input logic             rx_char_present,
  input logic [ERR_W-1:0] err_flags,
  input logic             id_rd,
  input logic             irq,
  input logic [3:0]       irq_id,
  input logic             rx_ready
);

  AST_LS_WINS: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) && $past(en_line_stat && (|err_flags)) |-> irq_id == 4'b0110); // R2

  AST_TO_FIFO_ONLY: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) && irq_id == 4'b1100 |-> $past(fifo_mode)); // R4

  AST_TE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) && $past(id_rd) && $past(irq_id) == 4'b0010 |-> irq_id != 4'b0010); // R6

  AST_NO_ENABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) && $past(!en_thr_empty && !en_rx_data && !en_line_stat)
      |-> !irq && irq_id == 4'b0001); // R7

  AST_IRQ_TRACKS_ID: assert property (@(posedge clk) disable iff (!rst_s)
    irq == !irq_id[0]); // R8

  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) |-> rx_ready == $past(rx_char_present)); // R9

endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk #(.ERR_W(ERR_W)) u_chk (
  .clk             (clk),
  .rst_s           (rst_s),
  .fifo_mode       (fifo_mode),
  .en_thr_empty    (en_thr_empty),
  .en_rx_data      (en_rx_data),
  .en_line_stat    (en_line_stat),
  .rx_char_present (rx_char_present),
  .err_flags       (err_flags),
  .id_rd           (id_rd),
  .irq             (irq),
  .irq_id          (irq_id),
  .rx_ready        (rx_ready)
);

// File: tb/uart_irq_arbiter_bench.sv
module uart_irq_arbiter_bench;

  logic       clk;
  logic       rst_n;
  logic       fifo_mode, en_thr_empty, en_rx_data, en_line_stat;
  logic       thr_empty, rx_char_present, rx_at_trigger, rx_timeout;
  logic [3:0] err_flags;
  logic       id_rd;
  logic       irq;
  logic [3:0] irq_id;
  logic       rx_ready;

  int errors = 0;
  int checks = 0;

  uart_irq_arbiter u_uart_irq_arbiter (
    .clk             (clk),
    .rst_n           (rst_n),
    .fifo_mode       (fifo_mode),
    .en_thr_empty    (en_thr_empty),
    .en_rx_data      (en_rx_data),
    .en_line_stat    (en_line_stat),
    .thr_empty       (thr_empty),
    .rx_char_present (rx_char_present),
    .rx_at_trigger   (rx_at_trigger),
    .rx_timeout      (rx_timeout),
    .err_flags       (err_flags),
    .id_rd           (id_rd),
    .irq             (irq),
    .irq_id          (irq_id),
    .rx_ready        (rx_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_out(input string tag, input logic [3:0] exp_id);
    chk({tag, " id"}, irq_id, exp_id);
    chk({tag, " irq"}, {3'b000, irq}, {3'b000, ~exp_id[0]});
  endtask

  function automatic logic [3:0] model_id(logic fm, logic el, logic er, logic et,
                                          logic ch, logic tr, logic tmo,
                                          logic [3:0] err, logic te_on);
    if (el && (err != 4'd0))        return 4'b0110;
    else if (er && (fm ? tr : ch))  return 4'b0100;
    else if (er && fm && tmo)       return 4'b1100;
    else if (et && te_on)           return 4'b0010;
    else                            return 4'b0001;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {fifo_mode, en_thr_empty, en_rx_data, en_line_stat} = '0;
    {thr_empty, rx_char_present, rx_at_trigger, rx_timeout} = '0;
    err_flags = '0;
    id_rd = 1'b0;
    repeat (3) step();
    // R1: reset values while reset is held
    chk("R1 irq", {3'b000, irq}, 4'b0000);
    chk("R1 id", irq_id, 4'b0001);
    chk("R1 rdy", {3'b000, rx_ready}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 id after release", irq_id, 4'b0001);

    // arm transmit-empty once, then sweep with it pending
    thr_empty = 1'b1;
    step();
    for (int c = 0; c < 2048; c++) begin
      fifo_mode       = c[0];
      en_thr_empty    = c[1];
      en_rx_data      = c[2];
      en_line_stat    = c[3];
      rx_char_present = c[4];
      rx_at_trigger   = c[5];
      rx_timeout      = c[6];
      err_flags       = c[10:7];
      step();
      // R2 R3 R4 R5 R7 R8: priority and gating across all combinations
      chk_out("R2-R8 sweep", model_id(c[0], c[3], c[2], c[1], c[4], c[5], c[6], c[10:7], 1'b1));
      chk("R9 rdy", {3'b000, rx_ready}, {3'b000, c[4]});
    end

    // transmit-empty event scenarios
    {fifo_mode, en_rx_data, en_line_stat} = '0;
    {rx_char_present, rx_at_trigger, rx_timeout} = '0;
    err_flags = '0;
    en_thr_empty = 1'b1;
    thr_empty = 1'b0;
    step(); step();
    chk_out("R5 not empty", 4'b0001);
    thr_empty = 1'b1;
    step();
    chk_out("R5 became empty", 4'b0010);
    id_rd = 1'b1;
    step();
    id_rd = 1'b0;
    chk_out("R6 cleared by read", 4'b0001);
    repeat (3) step();
    chk_out("R6 stays clear while empty", 4'b0001);
    thr_empty = 1'b0;
    step();
    thr_empty = 1'b1;
    step();
    chk_out("R6 rearm on transition", 4'b0010);

    en_line_stat = 1'b1;
    err_flags = 4'b0100;
    step();
    chk_out("R2 over transmit empty", 4'b0110);
    id_rd = 1'b1;
    step();
    id_rd = 1'b0;
    err_flags = 4'b0000;
    step();
    chk_out("R6 other-source read keeps TE", 4'b0010);
    id_rd = 1'b1;
    step();
    id_rd = 1'b0;
    chk_out("R6 second clear", 4'b0001);

    en_thr_empty = 1'b0;
    thr_empty = 1'b0;
    step();
    thr_empty = 1'b1;
    step();
    chk_out("R5 disabled hidden", 4'b0001);
    en_thr_empty = 1'b1;
    step();
    chk_out("R5 held while disabled", 4'b0010);
    thr_empty = 1'b0;
    step();
    chk_out("R5 withdrawn when filled", 4'b0001);

    // R9 / R3: FIFO mode below trigger shows ready but no request
    en_thr_empty = 1'b0;
    fifo_mode = 1'b1;
    en_rx_data = 1'b1;
    rx_char_present = 1'b1;
    step();
    chk_out("R3 below trigger", 4'b0001);
    chk("R9 ready below trigger", {3'b000, rx_ready}, 4'b0001);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule